// File: doc/BRIEF.md
# Auto-Ranging Four-Times-Sample-Rate Strobe Synthesizer

This block runs on a master clock that is an unknown integer multiple N of four times the audio sample rate, with N between 45 and 128. It finds N without any configuration. It counts master-clock cycles between rising edges of the serial-audio word-select line and divides that count by four. It then divides the master clock by N to produce a one-cycle strobe four times per sample period. Downstream logic uses this strobe to latch converter data words and to clock its up-sampling filters.

A 2-bit index tags each strobe with its position inside the sample period. A lock output reports that an accepted, stable divide ratio is in use. With the mode pin low, which is the default, the strobe comes only from the divider, so timing noise on word-select never moves it. With the mode pin high, every word-select rising edge reloads the divider, and the strobe with index 0 then lines up with the frame start.

The interface is control and status only. There is no data stream and no back-pressure. The strobe is a single-cycle pulse that downstream logic must take in the cycle it appears.

Top module: `fsq_synth`

## Requirements
- R1: After reset, `strobe_4fs` and `locked` are 0 and `phase_idx` is 3. The divider starts at 128, so with word-select idle the strobe fires every 128 master-clock cycles.
- R2: The measured ratio is the count of master-clock cycles between two synchronized word-select rising edges, shifted right by two. A ratio in 45..128 that equals the previous measurement becomes the divide ratio and sets `locked`. The first rising edge after reset produces no measurement.
- R3: In free-running mode, successive strobes are exactly N cycles apart, and each strobe is high for one cycle.
- R4: `phase_idx` changes only in a cycle where the strobe is high. In free-running mode it advances by one modulo 4 on each strobe, so the first strobe after reset carries index 0.
- R5: With `phase_lock_sel` low, a shift in the timing of word-select edges that leaves each measured ratio within one of the previous one does not change the strobe spacing.
- R6: A measured ratio outside 45..128 clears `locked` and leaves the divide ratio unchanged.
- R7: An in-range measurement that differs from the previous measurement by more than one clears `locked` and leaves the divide ratio unchanged. Two equal measurements in a row then relock at the new ratio.
- R8: An in-range measurement that differs from the previous one by exactly one leaves `locked` and the divide ratio unchanged.
- R9: With `phase_lock_sel` high, a word-select level first sampled high at clock edge k yields a strobe with `phase_idx` 0 visible after edge k+2, wherever the divider was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mclk | input | 1 | Master clock, N times four times the sample rate |
| rst_n | input | 1 | Active-low synchronous reset |
| ws_in | input | 1 | Word-select line, asynchronous to the master clock |
| phase_lock_sel | input | 1 | 0: free-running division; 1: realign to word-select rising edges |
| strobe_4fs | output | 1 | One-cycle strobe at four times the sample rate |
| phase_idx | output | 2 | Index 0..3 of the latest strobe within the sample period |
| locked | output | 1 | A stable, in-range divide ratio is in use |

## Verification
The embedded properties check, on every cycle, that the phase index stays still between strobes and steps by one on each free-running strobe. They also check that a free-running strobe lasts a single cycle, that the divide ratio stays within 45..128, that it changes only on a matching measurement while locked, and that a rejected measurement drops lock without touching the ratio. Only the bench scenarios can show the end-to-end arithmetic: that a word-select period of 4N cycles really produces strobes N cycles apart, that jittered or out-of-range periods leave the spacing intact, and that realignment places index 0 exactly three edges after word-select rises.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
  localparam int FSQ_N_MIN    = 45;
  localparam int FSQ_N_MAX    = 128;
  localparam int FSQ_SYNC_LEN = 2;
  localparam int FSQ_STROBES  = 4;
  localparam int FSQ_PH_W     = $clog2(FSQ_STROBES);
endpackage

// File: rtl/fsq_ws_sync.sv
module fsq_ws_sync #(
  parameter int STAGES = fsq_pkg::FSQ_SYNC_LEN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ws_async,
  output logic ws_rise
);
  logic [STAGES-1:0] chain;
  logic              ws_last;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= ws_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) ws_last <= 1'b0;
    else        ws_last <= chain[STAGES-1];
  end

  assign ws_rise = chain[STAGES-1] & ~ws_last;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ws_rise |=> !ws_rise); // R9
endmodule

// File: rtl/fsq_period_meter.sv
module fsq_period_meter #(
  parameter int P_W = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ws_rise,
  output logic           meas_vld,
  output logic [P_W-1:0] meas_len
);
  localparam logic [P_W-1:0] CNT_TOP = {P_W{1'b1}};
  localparam logic [P_W-1:0] CNT_ONE = P_W'(1);

  logic [P_W-1:0] run_cnt;
  logic           seen_edge;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt   <= '0;
      seen_edge <= 1'b0;
      meas_vld  <= 1'b0;
      meas_len  <= '0;
    end else if (ws_rise) begin
      run_cnt   <= CNT_ONE;
      seen_edge <= 1'b1;
      meas_vld  <= seen_edge;
      meas_len  <= run_cnt;
    end else begin
      meas_vld  <= 1'b0;
      if (run_cnt != CNT_TOP) run_cnt <= run_cnt + CNT_ONE;
    end
  end

  AST_MEAS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    meas_vld |=> !meas_vld); // R2
endmodule

// File: rtl/fsq_ratio_tracker.sv
module fsq_ratio_tracker #(
  parameter int N_MIN = fsq_pkg::FSQ_N_MIN,
  parameter int N_MAX = fsq_pkg::FSQ_N_MAX,
  parameter int N_W   = $clog2(N_MAX + 1),
  parameter int P_W   = $clog2(4 * N_MAX + 1) + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           meas_vld,
  input  logic [P_W-1:0] meas_len,
  output logic [N_W-1:0] div_n,
  output logic           locked
);
  localparam int M_W = P_W - 2;
  localparam logic [M_W-1:0] LO_V  = M_W'(N_MIN);
  localparam logic [M_W-1:0] HI_V  = M_W'(N_MAX);
  localparam logic [M_W-1:0] ONE_V = M_W'(1);
  localparam logic [N_W-1:0] RST_N = N_W'(N_MAX);

  logic [M_W-1:0] n_meas;
  logic [M_W-1:0] n_prev;
  logic [M_W-1:0] n_gap;
  logic           prev_ok;
  logic           in_range;
  logic           same;
  logic           far;

  assign n_meas   = meas_len[P_W-1:2];
  assign in_range = (n_meas >= LO_V) && (n_meas <= HI_V);
  assign same     = prev_ok && (n_meas == n_prev);
  assign n_gap    = (n_meas > n_prev) ? (n_meas - n_prev) : (n_prev - n_meas);
  assign far      = prev_ok && (n_gap > ONE_V);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_n   <= RST_N;
      locked  <= 1'b0;
      n_prev  <= '0;
      prev_ok <= 1'b0;
    end else if (meas_vld) begin
      if (!in_range) begin
        locked  <= 1'b0;
        prev_ok <= 1'b0;
      end else begin
        if (same) begin
          div_n  <= N_W'(n_meas);
          locked <= 1'b1;
        end else if (far) begin
          locked <= 1'b0;
        end
        prev_ok <= 1'b1;
        n_prev  <= n_meas;
      end
    end
  end

  AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (div_n >= N_W'(N_MIN)) && (div_n <= N_W'(N_MAX))); // R6
  AST_BAD_MEAS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    meas_vld && !in_range |=> !locked && $stable(div_n)); // R6
  AST_FAR_MEAS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    meas_vld && in_range && far |=> !locked && $stable(div_n)); // R7
  AST_DIV_MOVES_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    div_n != $past(div_n) |-> locked && $past(meas_vld)); // R2
endmodule

// File: rtl/fsq_strobe_divider.sv
module fsq_strobe_divider #(
  parameter int N_W  = 8,
  parameter int PH_W = fsq_pkg::FSQ_PH_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_W-1:0]  div_n,
  input  logic            ws_rise,
  input  logic            align_en,
  output logic            strobe,
  output logic [PH_W-1:0] phase
);
  localparam logic [N_W-1:0]  ONE_N  = N_W'(1);
  localparam logic [PH_W-1:0] ONE_P  = PH_W'(1);
  localparam logic [PH_W-1:0] LAST_P = {PH_W{1'b1}};

  logic [N_W-1:0] div_cnt;
  logic           wrap;

  assign wrap = (div_cnt >= (div_n - ONE_N));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt <= '0;
      strobe  <= 1'b0;
      phase   <= LAST_P;
    end else if (align_en && ws_rise) begin
      div_cnt <= '0;
      strobe  <= 1'b1;
      phase   <= '0;
    end else if (wrap) begin
      div_cnt <= '0;
      strobe  <= 1'b1;
      phase   <= phase + ONE_P;
    end else begin
      div_cnt <= div_cnt + ONE_N;
      strobe  <= 1'b0;
    end
  end

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |-> $stable(phase)); // R4
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && !$past(align_en) |-> phase == PH_W'($past(phase) + ONE_P)); // R4
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && !align_en |=> !strobe); // R3
endmodule

// File: rtl/fsq_synth.sv
module fsq_synth #(
  parameter int N_MIN = fsq_pkg::FSQ_N_MIN,
  parameter int N_MAX = fsq_pkg::FSQ_N_MAX
) (
  input  logic       clk_mclk,
  input  logic       rst_n,
  input  logic       ws_in,
  input  logic       phase_lock_sel,
  output logic       strobe_4fs,
  output logic [1:0] phase_idx,
  output logic       locked
);
  localparam int N_W = $clog2(N_MAX + 1);
  localparam int P_W = $clog2(4 * N_MAX + 1) + 1;

  logic           ws_rise;
  logic           meas_vld;
  logic [P_W-1:0] meas_len;
  logic [N_W-1:0] div_n;

  fsq_ws_sync #(.STAGES(fsq_pkg::FSQ_SYNC_LEN)) u_sync (
    .clk      (clk_mclk),
    .rst_n    (rst_n),
    .ws_async (ws_in),
    .ws_rise  (ws_rise)
  );

  fsq_period_meter #(.P_W(P_W)) u_meter (
    .clk      (clk_mclk),
    .rst_n    (rst_n),
    .ws_rise  (ws_rise),
    .meas_vld (meas_vld),
    .meas_len (meas_len)
  );

  fsq_ratio_tracker #(
    .N_MIN (N_MIN),
    .N_MAX (N_MAX),
    .N_W   (N_W),
    .P_W   (P_W)
  ) u_track (
    .clk      (clk_mclk),
    .rst_n    (rst_n),
    .meas_vld (meas_vld),
    .meas_len (meas_len),
    .div_n    (div_n),
    .locked   (locked)
  );

  fsq_strobe_divider #(.N_W(N_W), .PH_W(2)) u_div (
    .clk      (clk_mclk),
    .rst_n    (rst_n),
    .div_n    (div_n),
    .ws_rise  (ws_rise),
    .align_en (phase_lock_sel),
    .strobe   (strobe_4fs),
    .phase    (phase_idx)
  );
endmodule

// File: tb/tb_fsq_synth.sv
module tb_fsq_synth;
  localparam int CLK_HALF = 5;
  localparam int WD_LIMIT = 190000;

  logic       clk_mclk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ws_in = 1'b0;
  logic       phase_lock_sel = 1'b0;
  logic       strobe_4fs;
  logic [1:0] phase_idx;
  logic       locked;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit ph_watch = 1'b0;
  logic [1:0] ph_prev = 2'd3;
  bit lock_watch = 1'b0;
  bit lock_dropped = 1'b0;

  fsq_synth dut (
    .clk_mclk       (clk_mclk),
    .rst_n          (rst_n),
    .ws_in          (ws_in),
    .phase_lock_sel (phase_lock_sel),
    .strobe_4fs     (strobe_4fs),
    .phase_idx      (phase_idx),
    .locked         (locked)
  );

  always #CLK_HALF clk_mclk = ~clk_mclk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk_mclk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      chk(1'b0, "watchdog", cyc, WD_LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // R4: free-running phase index steps by one modulo 4 on each strobe
  always @(negedge clk_mclk) begin
    if (ph_watch && strobe_4fs) begin
      chk(phase_idx == 2'(ph_prev + 2'd1), "R4 phase step", phase_idx, 2'(ph_prev + 2'd1));
      ph_prev = phase_idx;
    end
    if (lock_watch && !locked) lock_dropped = 1'b1;
  end

  task automatic ws_periods(input int p, input int k);
    for (int i = 0; i < k; i++) begin
      ws_in = 1'b1;
      repeat (p / 2) @(negedge clk_mclk);
      ws_in = 1'b0;
      repeat (p - p / 2) @(negedge clk_mclk);
    end
  endtask

  task automatic wait_strobe();
    do @(negedge clk_mclk); while (!strobe_4fs);
  endtask

  task automatic expect_gap(input int exp, input int n, input string tag);
    wait_strobe();
    for (int i = 0; i < n; i++) begin
      int g = 0;
      do begin @(negedge clk_mclk); g++; end while (!strobe_4fs);
      chk(g == exp, tag, g, exp);
    end
  endtask

  // R9: in phase-locked mode a strobe with index 0 follows each rise by three edges
  task automatic ws_aligned(input int p);
    ws_in = 1'b1;
    repeat (3) @(negedge clk_mclk);
    chk(strobe_4fs == 1'b1, "R9 strobe at frame start", strobe_4fs, 1);
    chk(phase_idx == 2'd0, "R9 index at frame start", phase_idx, 0);
    repeat (p / 2 - 3) @(negedge clk_mclk);
    ws_in = 1'b0;
    repeat (p - p / 2) @(negedge clk_mclk);
  endtask

  initial begin
    repeat (4) @(negedge clk_mclk);
    rst_n = 1'b1;
    @(negedge clk_mclk);
    chk(strobe_4fs == 1'b0, "R1 strobe after reset", strobe_4fs, 0);
    chk(locked == 1'b0, "R1 lock after reset", locked, 0);
    chk(phase_idx == 2'd3, "R1 index after reset", phase_idx, 3);
    ph_watch = 1'b1;
    expect_gap(128, 2, "R1 default divide");

    // R2 R3: sweep the ratio range
    for (int n = 45; n <= 128; n += 9) begin
      ws_periods(4 * n, 5);
      chk(locked == 1'b1, "R2 lock after sweep step", locked, 1);
      fork
        ws_periods(4 * n, 2);
        expect_gap(n, 4, "R3 strobe spacing");
      join
    end
    ws_periods(4 * 128, 5);
    chk(locked == 1'b1, "R2 lock at top ratio", locked, 1);
    fork
      ws_periods(512, 2);
      expect_gap(128, 4, "R3 spacing at top ratio");
    join

    ws_periods(280, 5);
    chk(locked == 1'b1, "R2 lock at 70", locked, 1);

    // R8: off-by-one measurements keep lock and ratio
    lock_dropped = 1'b0;
    lock_watch = 1'b1;
    ws_periods(284, 1);
    ws_periods(280, 3);
    lock_watch = 1'b0;
    chk(lock_dropped == 1'b0, "R8 lock held through +-1", lock_dropped, 0);
    fork
      ws_periods(280, 2);
      expect_gap(70, 4, "R8 ratio unchanged");
    join

    // R5: shifted word-select edges leave strobe spacing alone
    fork
      begin ws_periods(282, 1); ws_periods(278, 1); ws_periods(280, 2); end
      expect_gap(70, 12, "R5 spacing under edge shift");
    join

    // R6: too short a period
    ws_periods(160, 3);
    chk(locked == 1'b0, "R6 lock cleared low", locked, 0);
    expect_gap(70, 2, "R6 ratio held low");
    ws_periods(280, 5);
    chk(locked == 1'b1, "R6 relock", locked, 1);
    ws_periods(520, 3);
    chk(locked == 1'b0, "R6 lock cleared high", locked, 0);
    expect_gap(70, 2, "R6 ratio held high");

    // R7: big jump
    ws_periods(240, 5);
    chk(locked == 1'b1, "R7 lock at 60", locked, 1);
    ws_periods(400, 1);
    fork
      ws_periods(400, 1);
      begin
        repeat (10) @(negedge clk_mclk);
        chk(locked == 1'b0, "R7 lock cleared on jump", locked, 0);
        expect_gap(60, 2, "R7 ratio held on jump");
      end
    join
    ws_periods(400, 3);
    chk(locked == 1'b1, "R7 relock at 100", locked, 1);
    fork
      ws_periods(400, 2);
      expect_gap(100, 4, "R7 new spacing");
    join

    // R9: phase-locked mode
    ph_watch = 1'b0;
    phase_lock_sel = 1'b1;
    ws_periods(256, 5);
    chk(locked == 1'b1, "R9 lock at 64", locked, 1);
    ws_aligned(256);
    ws_aligned(256);
    ws_aligned(259);
    ws_aligned(256);
    ws_aligned(256);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule